// File: doc/BRIEF.md
# Ternary Line Decoder

This block turns the two pulse rails of a single E1 or T1/J1 receive channel back into a binary bit stream. On every cycle of the recovered receive clock it takes one bit period: a positive-rail bit and a negative-rail bit. It checks the alternating-mark rule and removes the zero-substitution patterns that the transmitter inserted. It then delivers one data bit with a valid strobe after a fixed delay.

A two-bit selector picks the line code: plain alternate mark inversion, the E1 four-zero substitution code (HDB3), or the T1/J1 eight-zero substitution code (B8ZS). A strictness bit adds two further checks: a rule on the polarity of successive violations, and a limit on the length of zero runs on the line. The decoder never repairs the stream. Every bit period that carries an error adds one to a 16-bit saturating error counter, which the host reads on a port and clears with a synchronous strobe.

Top module: `ternary_line_decoder`

## Requirements
- R1: While `rst` is high, `dec_vld`, `dec_bit` and `cv_count` are zero. Once reset is released, `dec_vld` stays high from its first rise until the next reset.
- R2: `code_sel` selects the code as follows: 2'b00 and 2'b11 select AMI, 2'b01 selects HDB3 and 2'b10 selects B8ZS. A symbol sampled at clock edge k appears on `dec_bit` after edge k+4 for AMI and HDB3, and after edge k+8 for B8ZS. A mark decodes as 1 and a space decodes as 0.
- R3: In AMI, a single-rail mark whose polarity equals that of the previous single-rail mark is a violation. It adds one to `cv_count` and is still decoded as 1.
- R4: In HDB3, the groups space-space-space-V and B-space-space-V each decode as four zeros and add nothing to `cv_count`. Here V is a violation mark and B is a mark that follows the alternation rule.
- R5: In B8ZS, the group 0,0,0,V,B,0,V,B decodes as eight zeros and adds nothing to `cv_count`.
- R6: In HDB3 and B8ZS, a violation that is not part of a recognised group adds one to `cv_count` and is decoded as 1.
- R7: A bit period with a pulse on both rails adds one to `cv_count` and decodes as 1. It leaves the polarity reference for the next mark unchanged.
- R8: With `ext_chk` high in HDB3, a violation with the same polarity as the previous violation adds one to `cv_count`, even inside a recognised group. With `ext_chk` low it does not.
- R9: With `ext_chk` high, the 4th consecutive line space in HDB3, or the 8th in B8ZS, adds one to `cv_count`, and the run count then restarts. AMI has no such limit, and with `ext_chk` low the rule is off.
- R10: A single bit period adds at most one to `cv_count`, however many error conditions it meets.
- R11: `cv_count` stops at 16'hFFFF.
- R12: `cnt_clr` clears `cv_count` to zero on the next edge, even when an increment falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock, one bit period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_p | input | 1 | Positive pulse rail |
| rx_n | input | 1 | Negative pulse rail |
| code_sel | input | 2 | Line code select (see R2) |
| ext_chk | input | 1 | Enables the extended error checks |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| dec_bit | output | 1 | Decoded data bit |
| dec_vld | output | 1 | Decoded bit valid strobe |
| cv_count | output | 16 | Saturating code-violation count |

## Verification
The host clear and an error increment can land on the same clock edge. The bench provokes this by holding a continuous stream of AMI violations, so that an increment is due on every edge. It then pulses `cnt_clr` for one cycle. The count must read zero after that edge and one after the next edge, which shows that the clear wins and that counting resumes at once. The same overlap is provoked at the top of the range, where the count is held at 16'hFFFF by saturation when the clear arrives.

// File: rtl/tld_pkg.sv
package tld_pkg;

  typedef enum logic [1:0] {
    CODE_AMI     = 2'b00,
    CODE_HDB3    = 2'b01,
    CODE_B8ZS    = 2'b10,
    CODE_AMI_ALT = 2'b11
  } line_code_e;

  // one bit period as it travels through the window
  typedef struct packed {
    logic vld;   // stage holds a real symbol
    logic mark;  // pulse on at least one rail
    logic viol;  // single-rail mark repeating the previous polarity
    logic dbl;   // pulse on both rails
    logic xv;    // violation repeating the previous violation polarity
    logic zx;    // space that completes an over-long zero run
    logic sub;   // part of a recognised substitution group
  } sym_t;

  localparam int unsigned HDB3_LEN = 4;
  localparam int unsigned B8ZS_LEN = 8;

endpackage

// File: rtl/tld_sym_class.sv
module tld_sym_class
  import tld_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_p,
  input  logic       rx_n,
  input  line_code_e code,
  output sym_t       sym_o
);

  localparam int ZW = $clog2(B8ZS_LEN + 1);

  logic          last_pol, have_mark;
  logic          last_vpol, have_v;
  logic [ZW-1:0] zrun, zrun_nx, lim;
  logic          mark, dbl, single, pol, viol, xv, zx;

  always_comb begin
    mark    = rx_p | rx_n;
    dbl     = rx_p & rx_n;
    single  = rx_p ^ rx_n;
    pol     = rx_p;
    viol    = single & have_mark & (pol == last_pol);
    xv      = viol & (code == CODE_HDB3) & have_v & (pol == last_vpol);
    case (code)
      CODE_HDB3: lim = ZW'(HDB3_LEN);
      CODE_B8ZS: lim = ZW'(B8ZS_LEN);
      default:   lim = '0;
    endcase
    zrun_nx = (zrun == '1) ? zrun : zrun + 1'b1;
    zx      = ~mark & (lim != '0) & (zrun_nx == lim);

    sym_o      = '0;
    sym_o.vld  = 1'b1;
    sym_o.mark = mark;
    sym_o.viol = viol;
    sym_o.dbl  = dbl;
    sym_o.xv   = xv;
    sym_o.zx   = zx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pol  <= 1'b0;
      have_mark <= 1'b0;
      last_vpol <= 1'b0;
      have_v    <= 1'b0;
      zrun      <= '0;
    end else begin
      if (single) begin
        last_pol  <= pol;
        have_mark <= 1'b1;
      end
      if (viol) begin
        last_vpol <= pol;
        have_v    <= 1'b1;
      end
      if (mark || zx) zrun <= '0;
      else            zrun <= zrun_nx;
    end
  end

  // R7: a both-rail pulse leaves the polarity reference untouched
  a_r7_dbl_keeps_ref: assert property (@(posedge clk) disable iff (rst)
    (rx_p && rx_n) |=> (last_pol == $past(last_pol) && have_mark == $past(have_mark)));

endmodule

// File: rtl/tld_subst_pipe.sv
module tld_subst_pipe
  import tld_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  line_code_e code,
  input  sym_t       in_sym,
  output sym_t       exit_sym
);

  localparam int DEPTH = B8ZS_LEN;

  sym_t st [DEPTH];
  sym_t nw [DEPTH];
  logic hdb_hit, b8_hit;

  function automatic logic is_space(sym_t s);
    return s.vld & ~s.mark;
  endfunction

  function automatic logic is_bmark(sym_t s);
    return s.vld & s.mark & ~s.viol & ~s.dbl;
  endfunction

  function automatic logic is_vmark(sym_t s);
    return s.vld & s.viol;
  endfunction

  // window as it will stand after this edge; index 0 is the newest symbol
  always_comb begin
    nw[0] = in_sym;
    for (int i = 1; i < DEPTH; i++) nw[i] = st[i-1];
  end

  always_comb begin
    hdb_hit = (code == CODE_HDB3) & is_vmark(nw[0]) & is_space(nw[1]) & is_space(nw[2]) &
              (is_space(nw[3]) | is_bmark(nw[3]));
    b8_hit  = (code == CODE_B8ZS) & is_bmark(nw[0]) & is_vmark(nw[1]) & is_space(nw[2]) &
              is_bmark(nw[3]) & is_vmark(nw[4]) & is_space(nw[5]) & is_space(nw[6]) &
              is_space(nw[7]);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    localparam logic IN_HDB = (g < HDB3_LEN);
    sym_t nxt;
    always_comb begin
      nxt     = nw[g];
      nxt.sub = nw[g].sub | (hdb_hit & IN_HDB) | b8_hit;
    end
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '0;
      else     st[g] <= nxt;
    end
  end

  always_comb exit_sym = (code == CODE_B8ZS) ? st[B8ZS_LEN-1] : st[HDB3_LEN-1];

endmodule

// File: rtl/tld_cv_counter.sv
module tld_cv_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)             count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R12: the clear wins over a same-cycle increment
  a_r12_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R11: the count holds at its ceiling
  a_r11_hold_top: assert property (@(posedge clk) disable iff (rst)
    (!clr && count == TOP) |=> (count == TOP));

  // R10: without a clear the count moves by at most one per bit period
  a_r10_step_one: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count == $past(count) || count == W'($past(count) + 1'b1)));

endmodule

// File: rtl/ternary_line_decoder.sv
module ternary_line_decoder
  import tld_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_p,
  input  logic             rx_n,
  input  logic [1:0]       code_sel,
  input  logic             ext_chk,
  input  logic             cnt_clr,
  output logic             dec_bit,
  output logic             dec_vld,
  output logic [CNT_W-1:0] cv_count
);

  line_code_e code;
  sym_t       in_sym, ex;
  logic       err;

  assign code = line_code_e'(code_sel);

  tld_sym_class u_class (
    .clk   (clk),
    .rst   (rst),
    .rx_p  (rx_p),
    .rx_n  (rx_n),
    .code  (code),
    .sym_o (in_sym)
  );

  tld_subst_pipe u_pipe (
    .clk      (clk),
    .rst      (rst),
    .code     (code),
    .in_sym   (in_sym),
    .exit_sym (ex)
  );

  // all error sources of one bit period merge into a single increment
  always_comb
    err = ex.vld & ((ex.viol & ~ex.sub) | ex.dbl | (ext_chk & (ex.xv | ex.zx)));

  tld_cv_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (err),
    .count (cv_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_bit <= 1'b0;
      dec_vld <= 1'b0;
    end else begin
      dec_bit <= ex.vld & ex.mark & ~ex.sub;
      dec_vld <= ex.vld;
    end
  end

  // R1: once valid, the strobe stays up until reset
  a_r1_vld_sticky: assert property (@(posedge clk) disable iff (rst)
    dec_vld |=> dec_vld);

  // R7: both-rail pulse comes out as a one, four bit periods later (AMI/HDB3)
  a_r7_dbl_is_one: assert property (@(posedge clk) disable iff (rst)
    (rx_p && rx_n && code_sel != 2'b10) |-> ##5 (dec_vld && dec_bit));

endmodule

// File: tb/tb_ternary_line_decoder.sv
`timescale 1ns/1ps
module tb_ternary_line_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_p = 1'b0, rx_n = 1'b0;
  logic [1:0]  code_sel = 2'b00;
  logic        ext_chk = 1'b0;
  logic        cnt_clr = 1'b0;
  logic        dec_bit, dec_vld;
  logic [15:0] cv_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit outq [$];

  always #5 clk = ~clk;

  ternary_line_decoder dut (
    .clk(clk), .rst(rst), .rx_p(rx_p), .rx_n(rx_n), .code_sel(code_sel),
    .ext_chk(ext_chk), .cnt_clr(cnt_clr), .dec_bit(dec_bit), .dec_vld(dec_vld),
    .cv_count(cv_count)
  );

  always @(negedge clk) if (!rst && dec_vld) outq.push_back(dec_bit);

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_sym(byte c);
    case (c)
      "+":     begin rx_p = 1'b1; rx_n = 1'b0; end
      "-":     begin rx_p = 1'b0; rx_n = 1'b1; end
      "*":     begin rx_p = 1'b1; rx_n = 1'b1; end
      default: begin rx_p = 1'b0; rx_n = 1'b0; end
    endcase
  endtask

  // leaves the bench at a falling edge with reset still high
  task automatic do_reset(logic [1:0] code, bit ext);
    @(negedge clk);
    rst = 1'b1; code_sel = code; ext_chk = ext; cnt_clr = 1'b0;
    drive_sym("0");
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset(2'b00, 1'b0);
    check(dec_vld == 1'b0, "R1", "dec_vld in reset", int'(dec_vld), 0);
    check(dec_bit == 1'b0, "R1", "dec_bit in reset", int'(dec_bit), 0);
    check(cv_count == 16'd0, "R1", "cv_count in reset", int'(cv_count), 0);
  endtask

  task automatic test_latency(logic [1:0] code, int lat);
    do_reset(code, 1'b0);
    rst = 1'b0;
    drive_sym("+");
    for (int i = 1; i <= lat + 2; i++) begin
      @(negedge clk);
      drive_sym("0");
      if (i == lat)     check(dec_vld == 1'b0, "R2", "vld before latency", int'(dec_vld), 0);
      if (i == lat + 1) check(dec_vld && dec_bit, "R2", "first bit at latency",
                              int'({dec_vld, dec_bit}), 3);
      if (i == lat + 2) check(dec_bit == 1'b0, "R2", "space after mark", int'(dec_bit), 0);
    end
  endtask

  task automatic run_stream(string req, logic [1:0] code, bit ext, string s,
                            string exp_bits, int exp_err);
    int lat = (code == 2'b10) ? 8 : 4;
    int got_cnt;
    int mism = 0;
    do_reset(code, ext);
    outq.delete();
    for (int j = 0; j < s.len(); j++) begin
      if (j > 0) @(negedge clk);
      rst = 1'b0;
      drive_sym(s[j]);
    end
    @(negedge clk);
    drive_sym("0");
    repeat (lat) @(negedge clk);
    got_cnt = int'(cv_count);
    @(negedge clk);
    if (outq.size() < exp_bits.len()) mism = exp_bits.len();
    else
      for (int j = 0; j < exp_bits.len(); j++)
        if (outq[j] != (exp_bits[j] == "1")) mism++;
    check(mism == 0, req, {"decoded bits of ", s}, mism, 0);
    check(got_cnt == exp_err, req, {"error count of ", s}, got_cnt, exp_err);
  endtask

  task automatic test_saturate_and_clear();
    do_reset(2'b00, 1'b0);
    rst = 1'b0;
    drive_sym("+");
    repeat (65545) @(negedge clk);
    check(cv_count == 16'hFFFF, "R11", "count at ceiling", int'(cv_count), 65535);
    @(negedge clk);
    check(cv_count == 16'hFFFF, "R11", "count held at ceiling", int'(cv_count), 65535);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    check(cv_count == 16'd0, "R12", "clear beats increment", int'(cv_count), 0);
    @(negedge clk);
    check(cv_count == 16'd1, "R12", "count resumes after clear", int'(cv_count), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_reset();                                                  // R1
    test_latency(2'b00, 4);                                        // R2 AMI
    test_latency(2'b10, 8);                                        // R2 B8ZS
    run_stream("R3", 2'b00, 1'b0, "+0-0+-+0+--", "10101110111", 2);
    run_stream("R7", 2'b11, 1'b0, "+*-", "111", 1);
    run_stream("R4", 2'b01, 1'b0, "+000+-00-+0-", "100000000101", 0);
    run_stream("R6", 2'b01, 1'b0, "+-0-*+", "110111", 2);
    run_stream("R5", 2'b10, 1'b0, "+000+-0-+-", "1000000001", 0);
    run_stream("R6", 2'b10, 1'b0, "+000+-0-+-0-", "100000000101", 1);
    run_stream("R8", 2'b01, 1'b1, "+000+000+", "100000000", 1);
    run_stream("R8", 2'b01, 1'b0, "+000+000+", "100000000", 0);
    run_stream("R9", 2'b01, 1'b1, "+00000000-", "1000000001", 2);
    run_stream("R9", 2'b01, 1'b0, "+00000000-", "1000000001", 0);
    run_stream("R9", 2'b10, 1'b1, "+00000000-", "1000000001", 1);
    run_stream("R9", 2'b10, 1'b1, "+0000000-", "100000001", 0);
    run_stream("R9", 2'b00, 1'b1, "+00000000-", "1000000001", 0);
    run_stream("R10", 2'b01, 1'b1, "+-0-+-0-", "11011101", 2);
    test_saturate_and_clear();                                     // R11 R12
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule